// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps a small direct-mapped set of cache lines coherent on a shared, atomic snooping bus using a four-state write-back invalidate protocol. Each line is in one of four states: Invalid (I), Shared (S), Exclusive (E) or Modified (M). The block serves processor loads and stores. On a miss it arbitrates for the bus and issues a read, a read-for-ownership or a write-back. At the same time it watches transactions from other agents and answers them on the wired-OR snoop-result lines.

As a requester, the controller waits for the bus-wide snoop-valid line. Until that line rises, the Shared line may not be sampled. At that point Shared decides whether a read fill lands in E or in S. Memory and the other caches are outside the block. When some snooper raises Dirty, that owner supplies the data and memory stays silent. As a snooper, the controller raises Shared when it holds a copy and Dirty when that copy is Modified. A Modified line puts its data on the flush outputs.

The processor side runs as a four-state machine. IDLE looks up the line; a hit, or a write to E or M, completes there. ARB holds the bus request; on grant it issues a write-back or the miss command. SNOOP waits for snoop-valid and captures Shared. FILL waits for data and installs the line. The named transitions are IDLE->ARB (miss, or write to S), ARB->ARB (victim write-back), ARB->SNOOP (miss command issued), SNOOP->FILL (snoop-valid seen) and FILL->IDLE (data valid).

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. cpu_done_o, bus_req_o and snp_done_o are low, a snoop to any address raises no result line, and the first processor access misses.
- R2: A load miss holds bus_req_o and, in the grant cycle, drives bus_cmd_o = 1 (read) with the request address. It does not complete while bus_sv_i is low. The line fills in E if bus_shr_i was low in the cycle bus_sv_i was high, and in S otherwise. The processor gets bus_rdata_i in the cycle bus_dvld_i is high.
- R3: A store to an Invalid line, or to a line in S, issues bus_cmd_o = 2 (read-for-ownership). The line then holds the store data in M, and a later load hits and returns that data with no bus request.
- R4: A load that hits in S, E or M, and a store that hits in E or M, raise cpu_done_o in the cycle of the request without any bus request; a store hit in E moves the line to M silently.
- R5: Each snooped command yields snp_done_o exactly one cycle later. On a snooped read (snp_cmd_i = 1) of a held line, snp_shr_o is raised and the line goes to S. If the line was M, snp_dty_o and snp_flush_o are raised too, with the line data on snp_fdata_o.
- R6: On a snooped read-for-ownership (snp_cmd_i = 2) of a held line, snp_shr_o is raised and the line goes to Invalid. A Modified line also raises snp_dty_o and snp_flush_o with its data.
- R7: A snooped write-back (snp_cmd_i = 3) raises no result line and leaves the line state and data unchanged.
- R8: A miss whose line is Modified under a different tag first issues bus_cmd_o = 3 (write-back). That command carries the victim address ({tag, index}, index in the low bits) and the victim data on bus_wdata_o in the same cycle. The miss command follows on a later grant.
- R9: When a snoop and a processor access hit the same line index in the same cycle, the snoop is applied first and the processor access is not completed in that cycle. It then proceeds from the state the snoop left.
- R10: The bus command is chosen at grant time, not at miss detection. If a snoop invalidates a dirty victim while the request waits for grant, no write-back is issued.
- R11: bus_req_o stays high until bus_gnt_i arrives, and bus_cmd_o is non-zero only while both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor access request, held until cpu_done_o |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | TAG_W+IDX_W | Line address {tag, index} |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_done_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with cpu_done_o |
| bus_req_o | output | 1 | Bus arbitration request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr_o | output | TAG_W+IDX_W | Address of the issued command |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_shr_i | input | 1 | Wired-OR Shared from other caches |
| bus_sv_i | input | 1 | Snoop-valid: Shared may be sampled |
| bus_dvld_i | input | 1 | Fill data valid |
| bus_rdata_i | input | DATA_W | Fill data |
| snp_valid_i | input | 1 | Another agent's command is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | TAG_W+IDX_W | Snooped address |
| snp_done_o | output | 1 | This cache has finished its snoop |
| snp_shr_o | output | 1 | Contribution to wired-OR Shared |
| snp_dty_o | output | 1 | Contribution to wired-OR Dirty |
| snp_flush_o | output | 1 | Flush data is on snp_fdata_o |
| snp_fdata_o | output | DATA_W | Flushed line data |

## Verification
A snoop from another agent and a processor access can land on the same line index in the same cycle. A second collision occurs when a snoop hits a dirty victim while that line's replacement waits in ARB for the bus. The bench provokes the first case twice. One case drives a store to an Exclusive line together with a snooped read-for-ownership; the store must stall, the line must go Invalid, and a read-for-ownership must follow. The other drives a load of a Modified line together with a snooped read; the line must flush and the load must still hit in S one cycle later. For the second case, the bench snoops the victim during arbitration and then requires the grant to carry a plain read instead of a write-back.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_ARB   = 2'd1,
        P_SNOOP = 2'd2,
        P_FILL  = 2'd3
    } proc_state_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_state_t       a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_state_t       b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_state_t       s_state,
    input  logic              p_we,
    input  logic              p_tag_we,
    input  logic              p_data_we,
    input  logic [IDX_W-1:0]  p_idx,
    input  line_state_t       p_state,
    input  logic [TAG_W-1:0]  p_tag,
    input  logic [DATA_W-1:0] p_data
);
    localparam int LINES = 1 << IDX_W;

    line_state_t       st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= ST_I;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else begin
                // snoop update wins over a processor update to the same line
                if (s_we && s_idx == MY_IDX) begin
                    st_q[g] <= s_state;
                end else if (p_we && p_idx == MY_IDX) begin
                    st_q[g] <= p_state;
                end
                if (p_tag_we && p_idx == MY_IDX) begin
                    tag_q[g] <= p_tag;
                end
                if (p_data_we && p_idx == MY_IDX) begin
                    data_q[g] <= p_data;
                end
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  bus_cmd_t          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_state_t       ln_state,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              upd_we,
    output line_state_t       upd_state,
    output logic              done_o,
    output logic              shr_o,
    output logic              dty_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] fdata_o
);
    logic held;
    logic shr_n;
    logic dty_n;

    assign held = (ln_state != ST_I) && (ln_tag == snp_tag);

    always_comb begin
        upd_we    = 1'b0;
        upd_state = ln_state;
        shr_n     = 1'b0;
        dty_n     = 1'b0;
        if (snp_valid && held) begin
            unique case (snp_cmd)
                CMD_RD: begin
                    shr_n     = 1'b1;
                    dty_n     = (ln_state == ST_M);
                    upd_we    = (ln_state != ST_S);
                    upd_state = ST_S;
                end
                CMD_RDX: begin
                    shr_n     = 1'b1;
                    dty_n     = (ln_state == ST_M);
                    upd_we    = 1'b1;
                    upd_state = ST_I;
                end
                default: begin
                    // write-back or idle command: no effect on the line
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            shr_o   <= 1'b0;
            dty_o   <= 1'b0;
            flush_o <= 1'b0;
            fdata_o <= '0;
        end else begin
            done_o  <= snp_valid;
            shr_o   <= shr_n;
            dty_o   <= dty_n;
            flush_o <= dty_n;
            fdata_o <= dty_n ? ln_data : '0;
        end
    end

    AST_SNOOP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> done_o); // R5

    AST_FLUSH_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (dty_o && shr_o && done_o)); // R6

endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              conflict,
    input  line_state_t       lk_state,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              bus_gnt,
    input  logic              bus_shr,
    input  logic              bus_sv,
    input  logic              bus_dvld,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output bus_cmd_t          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              p_we,
    output logic              p_tag_we,
    output logic              p_data_we,
    output line_state_t       p_state,
    output logic [DATA_W-1:0] p_data
);
    proc_state_t st_q, st_n;
    logic        shr_q;
    logic        hit;
    logic        victim_dirty;
    logic        quick;

    assign hit          = (lk_state != ST_I) && (lk_tag == cpu_tag);
    assign victim_dirty = (lk_state == ST_M) && (lk_tag != cpu_tag);
    assign quick        = cpu_req && !conflict && hit &&
                          (!cpu_we || lk_state == ST_E || lk_state == ST_M);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= P_IDLE;
            shr_q <= 1'b0;
        end else begin
            st_q <= st_n;
            if (st_q == P_SNOOP && bus_sv) begin
                shr_q <= bus_shr;
            end
        end
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            P_IDLE:  if (cpu_req && !conflict && !quick) st_n = P_ARB;
            P_ARB:   if (bus_gnt && !victim_dirty)       st_n = P_SNOOP;
            P_SNOOP: if (bus_sv)                         st_n = P_FILL;
            P_FILL:  if (bus_dvld)                       st_n = P_IDLE;
        endcase
    end

    always_comb begin
        cpu_done  = 1'b0;
        cpu_rdata = '0;
        bus_req   = 1'b0;
        bus_cmd   = CMD_NONE;
        bus_addr  = {cpu_tag, cpu_idx};
        bus_wdata = '0;
        p_we      = 1'b0;
        p_tag_we  = 1'b0;
        p_data_we = 1'b0;
        p_state   = lk_state;
        p_data    = cpu_wdata;
        unique case (st_q)
            P_IDLE: begin
                if (quick) begin
                    cpu_done  = 1'b1;
                    cpu_rdata = lk_data;
                    if (cpu_we) begin
                        p_we      = 1'b1;
                        p_data_we = 1'b1;
                        p_state   = ST_M;
                    end
                end
            end
            P_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    if (victim_dirty) begin
                        bus_cmd   = CMD_WB;
                        bus_addr  = {lk_tag, cpu_idx};
                        bus_wdata = lk_data;
                        p_we      = 1'b1;
                        p_state   = ST_I;
                    end else begin
                        bus_cmd = cpu_we ? CMD_RDX : CMD_RD;
                    end
                end
            end
            P_SNOOP: begin
                // waiting for the snoop-valid line
            end
            P_FILL: begin
                if (bus_dvld) begin
                    cpu_done  = 1'b1;
                    cpu_rdata = cpu_we ? cpu_wdata : bus_rdata;
                    p_we      = 1'b1;
                    p_tag_we  = 1'b1;
                    p_data_we = 1'b1;
                    p_data    = cpu_we ? cpu_wdata : bus_rdata;
                    p_state   = cpu_we ? ST_M : (shr_q ? ST_S : ST_E);
                end
            end
        endcase
    end

    AST_CMD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_NONE) |-> (bus_req && bus_gnt)); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req); // R11

    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_WB) |-> (lk_state == ST_M && lk_tag != cpu_tag)); // R8

    AST_NO_DONE_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && st_q == P_IDLE) |-> !conflict); // R9

    AST_FILL_AFTER_SV: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == P_FILL) |-> $past(st_q == P_FILL || (st_q == P_SNOOP && bus_sv))); // R2

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_done_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_shr_i,
    input  logic              bus_sv_i,
    input  logic              bus_dvld_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_done_o,
    output logic              snp_shr_o,
    output logic              snp_dty_o,
    output logic              snp_flush_o,
    output logic [DATA_W-1:0] snp_fdata_o
);
    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    line_state_t       a_state, b_state, s_state, p_state;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data, p_data;
    logic              s_we, p_we, p_tag_we, p_data_we;
    logic              conflict;
    bus_cmd_t          cmd_out;

    assign cpu_idx  = cpu_addr_i[IDX_W-1:0];
    assign cpu_tag  = cpu_addr_i[ADDR_W-1:IDX_W];
    assign snp_idx  = snp_addr_i[IDX_W-1:0];
    assign snp_tag  = snp_addr_i[ADDR_W-1:IDX_W];
    assign conflict = snp_valid_i && (snp_idx == cpu_idx);

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_idx     (cpu_idx),
        .a_state   (a_state),
        .a_tag     (a_tag),
        .a_data    (a_data),
        .b_idx     (snp_idx),
        .b_state   (b_state),
        .b_tag     (b_tag),
        .b_data    (b_data),
        .s_we      (s_we),
        .s_idx     (snp_idx),
        .s_state   (s_state),
        .p_we      (p_we),
        .p_tag_we  (p_tag_we),
        .p_data_we (p_data_we),
        .p_idx     (cpu_idx),
        .p_state   (p_state),
        .p_tag     (cpu_tag),
        .p_data    (p_data)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid_i),
        .snp_cmd   (bus_cmd_t'(snp_cmd_i)),
        .snp_tag   (snp_tag),
        .ln_state  (b_state),
        .ln_tag    (b_tag),
        .ln_data   (b_data),
        .upd_we    (s_we),
        .upd_state (s_state),
        .done_o    (snp_done_o),
        .shr_o     (snp_shr_o),
        .dty_o     (snp_dty_o),
        .flush_o   (snp_flush_o),
        .fdata_o   (snp_fdata_o)
    );

    mesi_proc_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_proc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req_i),
        .cpu_we    (cpu_we_i),
        .cpu_tag   (cpu_tag),
        .cpu_idx   (cpu_idx),
        .cpu_wdata (cpu_wdata_i),
        .conflict  (conflict),
        .lk_state  (a_state),
        .lk_tag    (a_tag),
        .lk_data   (a_data),
        .bus_gnt   (bus_gnt_i),
        .bus_shr   (bus_shr_i),
        .bus_sv    (bus_sv_i),
        .bus_dvld  (bus_dvld_i),
        .bus_rdata (bus_rdata_i),
        .cpu_done  (cpu_done_o),
        .cpu_rdata (cpu_rdata_o),
        .bus_req   (bus_req_o),
        .bus_cmd   (cmd_out),
        .bus_addr  (bus_addr_o),
        .bus_wdata (bus_wdata_o),
        .p_we      (p_we),
        .p_tag_we  (p_tag_we),
        .p_data_we (p_data_we),
        .p_state   (p_state),
        .p_data    (p_data)
    );

    assign bus_cmd_o = cmd_out;

    AST_WB_SNOOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid_i && snp_cmd_i == 2'd3) |=> (!snp_shr_o && !snp_dty_o)); // R7

endmodule

// File: tb/tb_mesi_snoop_ctrl.sv
module tb_mesi_snoop_ctrl;
    localparam int IDX_W  = 2;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = IDX_W + TAG_W;
    localparam int LINES  = 1 << IDX_W;
    localparam int MEMSZ  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req, bus_gnt = 1'b0;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_shr = 1'b0, bus_sv = 1'b0, bus_dvld = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_done, snp_shr, snp_dty, snp_flush;
    logic [DATA_W-1:0] snp_fdata;

    int checks = 0;
    int errors = 0;

    // reference model: line states use 0=I 1=S 2=E 3=M
    int                m_st  [LINES];
    logic [TAG_W-1:0]  m_tag [LINES];
    logic [DATA_W-1:0] m_dat [LINES];
    logic [DATA_W-1:0] mem   [MEMSZ];

    always #5 clk = ~clk;

    mesi_snoop_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
        .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_shr_i(bus_shr),
        .bus_sv_i(bus_sv), .bus_dvld_i(bus_dvld), .bus_rdata_i(bus_rdata),
        .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
        .snp_done_o(snp_done), .snp_shr_o(snp_shr), .snp_dty_o(snp_dty),
        .snp_flush_o(snp_flush), .snp_fdata_o(snp_fdata)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic m_hit(input logic [ADDR_W-1:0] a);
        return m_st[a[IDX_W-1:0]] != 0 && m_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
    endfunction

    function automatic logic [1:0] exp_miss_cmd(input logic we);
        return we ? 2'd2 : 2'd1;
    endfunction

    function automatic int exp_fill_state(input logic we, input logic shr);
        return we ? 3 : (shr ? 1 : 2);
    endfunction

    // bus side of a miss; entered at a negedge+1 where the DUT has seen the miss in IDLE
    task automatic miss_flow(input logic we, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] wd, input logic shr,
                             input logic vsnoop, input string rq);
        int idx;
        logic [TAG_W-1:0] tg;
        logic [ADDR_W-1:0] vaddr;
        idx = int'(a[IDX_W-1:0]);
        tg  = a[ADDR_W-1:IDX_W];
        @(negedge clk); #1;
        chk("R11 req raised", {31'd0, bus_req}, 1);
        chk("R11 no cmd before grant", {30'd0, bus_cmd}, 0);
        if (vsnoop) begin
            vaddr = {m_tag[idx], a[IDX_W-1:0]};
            snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = vaddr;
            @(negedge clk); snp_valid = 1'b0; #1;
            chk("R10 victim flushed while waiting", {31'd0, snp_dty}, 1);
            chk("R10 victim flush data", {16'd0, snp_fdata}, {16'd0, m_dat[idx]});
            mem[vaddr] = m_dat[idx];
            m_st[idx] = 0;
            chk("R11 req held", {31'd0, bus_req}, 1);
        end
        bus_gnt = 1'b1; #1;
        if (m_st[idx] == 3 && m_tag[idx] != tg) begin
            vaddr = {m_tag[idx], a[IDX_W-1:0]};
            chk("R8 write-back cmd", {30'd0, bus_cmd}, 3);
            chk("R8 write-back addr", {26'd0, bus_addr}, {26'd0, vaddr});
            chk("R8 write-back data", {16'd0, bus_wdata}, {16'd0, m_dat[idx]});
            mem[vaddr] = m_dat[idx];
            m_st[idx] = 0;
            @(negedge clk); #1;
        end
        chk({rq, " miss cmd"}, {30'd0, bus_cmd}, {30'd0, exp_miss_cmd(we)});
        if (vsnoop) chk("R10 no write-back", {31'd0, bus_cmd == 2'd3}, 0);
        chk({rq, " miss addr"}, {26'd0, bus_addr}, {26'd0, a});
        @(negedge clk); bus_gnt = 1'b0; #1;
        chk("R11 cmd only with grant", {30'd0, bus_cmd}, 0);
        repeat (1 + ($urandom % 3)) begin
            @(negedge clk); #1;
            chk("R2 inhibited until snoop-valid", {31'd0, cpu_done}, 0);
        end
        bus_sv = 1'b1; bus_shr = shr;
        @(negedge clk);
        bus_sv = 1'b0; bus_shr = 1'b0;
        bus_dvld = 1'b1; bus_rdata = mem[a];
        #1;
        chk({rq, " fill done"}, {31'd0, cpu_done}, 1);
        if (!we) chk("R2 fill data", {16'd0, cpu_rdata}, {16'd0, mem[a]});
        m_tag[idx] = tg;
        m_dat[idx] = we ? wd : mem[a];
        m_st[idx]  = exp_fill_state(we, shr);
        @(negedge clk);
        bus_dvld = 1'b0; cpu_req = 1'b0;
    endtask

    task automatic cpu_op(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input logic shr);
        int idx;
        idx = int'(a[IDX_W-1:0]);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (m_hit(a) && (!we || m_st[idx] >= 2)) begin
            chk("R4 hit completes", {31'd0, cpu_done}, 1);
            chk("R4 hit has no bus request", {31'd0, bus_req}, 0);
            if (!we) chk("R4 hit data", {16'd0, cpu_rdata}, {16'd0, m_dat[idx]});
            else begin
                m_st[idx] = 3;
                m_dat[idx] = wd;
            end
            @(negedge clk);
            cpu_req = 1'b0;
        end else begin
            chk("R2 miss not done", {31'd0, cpu_done}, 0);
            miss_flow(we, a, wd, shr, 1'b0, we ? "R3" : "R2");
        end
    endtask

    task automatic snoop_op(input logic [1:0] cmd, input logic [ADDR_W-1:0] a);
        int idx;
        logic eh, ed;
        idx = int'(a[IDX_W-1:0]);
        eh = m_hit(a) && (cmd == 2'd1 || cmd == 2'd2);
        ed = eh && m_st[idx] == 3;
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R5 snoop done", {31'd0, snp_done}, 1);
        chk(cmd == 2'd3 ? "R7 shared" : (cmd == 2'd2 ? "R6 shared" : "R5 shared"),
            {31'd0, snp_shr}, {31'd0, eh});
        chk(cmd == 2'd2 ? "R6 dirty" : "R5 dirty", {31'd0, snp_dty}, {31'd0, ed});
        chk(cmd == 2'd2 ? "R6 flush" : "R5 flush", {31'd0, snp_flush}, {31'd0, ed});
        if (ed) begin
            chk("R5 flush data", {16'd0, snp_fdata}, {16'd0, m_dat[idx]});
            mem[a] = m_dat[idx];
        end
        if (eh) m_st[idx] = (cmd == 2'd1) ? 1 : 0;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < LINES; i++) begin
            m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
        end
        for (int i = 0; i < MEMSZ; i++) mem[i] = DATA_W'(16'h1000 + i * 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset cpu_done", {31'd0, cpu_done}, 0);
        chk("R1 reset bus_req", {31'd0, bus_req}, 0);
        chk("R1 reset snp_done", {31'd0, snp_done}, 0);
        snoop_op(2'd1, 6'h05);
        chk("R1 snoop after reset no shared", {31'd0, snp_shr}, 0);

        // R2: read miss without sharers -> E; write then silent (R4)
        cpu_op(1'b0, 6'h05, '0, 1'b0);
        cpu_op(1'b1, 6'h05, 16'hBEEF, 1'b0);
        cpu_op(1'b0, 6'h05, '0, 1'b0);
        // R2: read miss with sharers -> S; write must go to the bus (R3)
        cpu_op(1'b0, 6'h0A, '0, 1'b1);
        cpu_op(1'b1, 6'h0A, 16'h1234, 1'b0);
        cpu_op(1'b0, 6'h0A, '0, 1'b0);
        // R5: snoop read of M flushes and goes S; R6 snoop RDX of S invalidates
        snoop_op(2'd1, 6'h05);
        snoop_op(2'd2, 6'h05);
        cpu_op(1'b0, 6'h05, '0, 1'b0);
        // R7: write-back snoop to held line has no effect
        snoop_op(2'd3, 6'h05);
        cpu_op(1'b0, 6'h05, '0, 1'b0);
        // R5: snoop read of E -> S, then store must use the bus
        snoop_op(2'd1, 6'h05);
        cpu_op(1'b1, 6'h05, 16'h5A5A, 1'b0);
        // R8: miss replacing a Modified line writes it back first
        cpu_op(1'b0, 6'h15, '0, 1'b0);
        cpu_op(1'b0, 6'h05, '0, 1'b0);

        // R9: store to E line collides with snooped RDX on same line
        cpu_op(1'b0, 6'h07, '0, 1'b0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 6'h07; cpu_wdata = 16'hC0DE;
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 6'h07;
        #1;
        chk("R9 processor held off", {31'd0, cpu_done}, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R9 snoop saw exclusive copy", {31'd0, snp_shr}, 1);
        chk("R9 no dirty from E", {31'd0, snp_dty}, 0);
        m_st[3] = 0;
        miss_flow(1'b1, 6'h07, 16'hC0DE, 1'b0, 1'b0, "R9");

        // R9: load of M line collides with snooped read
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 6'h07;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 6'h07;
        #1;
        chk("R9 load held off", {31'd0, cpu_done}, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R9 flush on collision", {31'd0, snp_flush}, 1);
        chk("R9 flush data", {16'd0, snp_fdata}, 16'hC0DE);
        chk("R9 load hits afterwards", {31'd0, cpu_done}, 1);
        chk("R9 load data", {16'd0, cpu_rdata}, 16'hC0DE);
        mem[6'h07] = 16'hC0DE;
        m_st[3] = 1;
        @(negedge clk);
        cpu_req = 1'b0;

        // R10: dirty victim invalidated while waiting for grant
        cpu_op(1'b1, 6'h0E, 16'h7777, 1'b0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 6'h1E;
        #1;
        chk("R10 miss detected", {31'd0, cpu_done}, 0);
        miss_flow(1'b0, 6'h1E, '0, 1'b1, 1'b1, "R10");

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            logic [ADDR_W-1:0] ra;
            ra = {TAG_W'($urandom % 3), IDX_W'($urandom % LINES)};
            if (($urandom % 10) < 6) begin
                cpu_op(1'($urandom % 2), ra, DATA_W'($urandom), 1'($urandom % 2));
            end else begin
                snoop_op(2'(1 + ($urandom % 3)), ra);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule